// File: doc/BRIEF.md
# Touch-Screen Converter Serial Command Slave

This block is the digital serial front end of a touch-screen analog-to-digital converter. A host selects the block with an active-low chip select and clocks an 8-bit command in on the serial data input. The block waits for the first high bit and treats it as the start of the command. It then decodes a channel number, a result width (12 or 8 bits), a reference mode and a power mode. After one busy clock it shifts a result word out MSB first. The result word is taken from a parallel sample input, which stands in for the analog core.

The serial clock, data and select pins are sampled by a faster system clock through a configurable synchroniser, and acted on at detected serial-clock edges. The command receiver and the result transmitter run independently. The next command can therefore be clocked in while the previous result is still being read out. Power-state, pen-interrupt-enable and switch-drive outputs follow the power mode and the conversion activity. Analog multiplexing, reference switching and sampling are not modelled.

Top module: `touch_adc_serial`

## Requirements
- R1: While chip select is active, serial data bits are ignored until a 1 is sampled on a serial clock rising edge. That 1 is the start bit of the command.
- R2: The 7 bits after the start bit are taken MSB first as: channel (3 bits, bits 6:4 of the byte), width select (bit 3, 1 = 8-bit result), reference select (bit 2, 1 = single-ended) and power mode (bits 1:0). `chan_sel` shows the channel of the last complete command and changes only when a command completes.
- R3: `busy` is high for exactly one serial clock period, from the falling edge after the last command bit until the next falling edge. It is low at all other times.
- R4: With width select 0, the 12-bit sample (captured when `busy` rises) is driven on `dout` MSB first, one bit per falling edge, starting at the falling edge that ends `busy`. `dout` is then 0 for the following three clocks of the 24-clock frame. `dout_oe` is high exactly while chip select is active.
- R5: With width select 1, only the upper 8 bits of the sample are driven, MSB first, followed by 0.
- R6: With reference select 0 (ratiometric), `ratio_sw` is high while a conversion runs (from `busy` to the clock after the last result bit). With reference select 1, `ratio_sw` stays low.
- R7: A start bit is accepted again 16 serial clocks after the previous start bit in 12-bit mode, or 12 clocks after it in 8-bit mode. Ones on `din` before that point are ignored. This lets a new command overlap the readout of the previous result.
- R8: Power mode 00: `powered` is high only during a conversion. `penirq_en` and `yneg_sw` are high while idle. The first conversion after power-down returns the correct sample.
- R9: Power mode 01: `powered` is high only during a conversion. `penirq_en` and `yneg_sw` stay low.
- R10: Power modes 11 and 10 keep `powered` high with `penirq_en` and `yneg_sw` low. Mode 10 sets `rsvd_flag`, which stays set until reset.
- R11: Deasserting chip select at any time aborts the frame. `busy`, `dout`, `dout_oe` and `ratio_sw` drop, and the next selection starts again with a start-bit search.
- R12: After reset, `busy`, `dout`, `dout_oe`, `powered` and `rsvd_flag` are 0, and the power mode is 00 (`penirq_en` and `yneg_sw` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| din | input | 1 | Serial command data |
| sample_in | input | SAMPLE_W | Parallel sample word to be reported |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` (low = high impedance) |
| busy | output | 1 | Conversion start flag, one serial clock long |
| chan_sel | output | 3 | Decoded channel of the current command |
| powered | output | 1 | Converter core powered |
| penirq_en | output | 1 | Pen interrupt detection enabled |
| yneg_sw | output | 1 | Y-minus drive switch enabled in power-down |
| ratio_sw | output | 1 | Drive switches held during ratiometric conversion |
| rsvd_flag | output | 1 | Sticky flag: reserved power code received |

## Verification
The main path is driven with four command patterns:
- A 12-bit single-ended frame with leading zeros, which shows that hunting aligns the byte on the first one.
- An 8-bit ratiometric frame, which separates the two result widths and the two reference modes.
- Back-to-back 12-bit frames and back-to-back 8-bit frames, each with ones placed in the gap before the next start bit. If the block uses the wrong frame spacing, these ones are taken as a misaligned command and the second result comes out wrong.

Abort patterns, one during busy and one in the middle of a command byte, show that deselection resets the search and does not leave a stale bit count.

// File: rtl/touch_adc_pkg.sv
package touch_adc_pkg;

   // Power-mode field values (bits 1:0 of the command byte)
   typedef enum logic [1:0] {
      PWR_DOZE_PEN   = 2'b00,
      PWR_DOZE_QUIET = 2'b01,
      PWR_RSVD       = 2'b10,
      PWR_ON         = 2'b11
   } pwr_mode_t;

   // Command bits following the start bit, MSB first on the wire.
   // The field order is the wire order, so the received bits map directly.
   typedef struct packed {
      logic [2:0] chan;
      logic       short_res;
      logic       single_ref;
      pwr_mode_t  pwr;
   } cmd_t;

   localparam int CMD_BITS = $bits(cmd_t) + 1;

   typedef enum logic [1:0] {RX_HUNT, RX_BYTE, RX_GAP} rx_state_t;
   typedef enum logic [1:0] {TX_IDLE, TX_BUSY, TX_SHIFT} tx_state_t;

endpackage

// File: rtl/tadc_edge_sync.sv
module tadc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_in,
   input  logic sclk_in,
   input  logic din_in,
   output logic cs_act,
   output logic din_s,
   output logic rise,
   output logic fall
);
   logic [2:0] raw;
   logic [2:0] synced;
   logic       sclk_d;

   assign raw = {cs_n_in, sclk_in, din_in};

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         logic [2:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= 3'b100;
            end else begin
               stg[0] <= raw;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign synced = stg[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= synced[1];
   end

   assign cs_act = ~synced[2];
   assign din_s  = synced[0];
   assign rise   = cs_act &  synced[1] & ~sclk_d;
   assign fall   = cs_act & ~synced[1] &  sclk_d;

endmodule

// File: rtl/tadc_cmd_rx.sv
module tadc_cmd_rx
   import touch_adc_pkg::*;
#(
   parameter int FRAME_LONG  = 16,
   parameter int FRAME_SHORT = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_act,
   input  logic rise,
   input  logic din,
   output logic cmd_valid,
   output cmd_t cmd
);
   localparam int CNT_W = $clog2(FRAME_LONG + 1);

   rx_state_t        state;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] frame_len;
   logic [CMD_BITS-3:0] shreg;

   assign frame_len = cmd.short_res ? CNT_W'(FRAME_SHORT) : CNT_W'(FRAME_LONG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= RX_HUNT;
         cnt       <= '0;
         shreg     <= '0;
         cmd       <= '0;
         cmd_valid <= 1'b0;
      end else begin
         cmd_valid <= 1'b0;
         if (!cs_act) begin
            state <= RX_HUNT;
            cnt   <= '0;
         end else if (rise) begin
            case (state)
               RX_HUNT: begin
                  if (din) begin
                     state <= RX_BYTE;
                     cnt   <= CNT_W'(1);
                  end
               end
               RX_BYTE: begin
                  shreg <= {shreg[CMD_BITS-4:0], din};
                  cnt   <= cnt + CNT_W'(1);
                  if (cnt == CNT_W'(CMD_BITS - 1)) begin
                     cmd       <= cmd_t'({shreg, din});
                     cmd_valid <= 1'b1;
                     state     <= RX_GAP;
                  end
               end
               default: begin
                  cnt <= cnt + CNT_W'(1);
                  if (cnt + CNT_W'(1) == frame_len) state <= RX_HUNT;
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/tadc_res_tx.sv
module tadc_res_tx
   import touch_adc_pkg::*;
#(
   parameter int SAMPLE_W = 12,
   parameter int SHORT_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_act,
   input  logic                fall,
   input  logic                start,
   input  logic                short_res,
   input  logic [SAMPLE_W-1:0] sample,
   output logic                busy,
   output logic                dout,
   output logic                conv_active
);
   localparam int LEFT_W = $clog2(SAMPLE_W + 1);
   localparam int PAD_W  = SAMPLE_W - SHORT_W;

   tx_state_t           state;
   logic                go;
   logic [SAMPLE_W-1:0] shreg;
   logic [LEFT_W-1:0]   left;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TX_IDLE;
         go    <= 1'b0;
         busy  <= 1'b0;
         dout  <= 1'b0;
         shreg <= '0;
         left  <= '0;
      end else if (!cs_act) begin
         state <= TX_IDLE;
         go    <= 1'b0;
         busy  <= 1'b0;
         dout  <= 1'b0;
         left  <= '0;
      end else begin
         if (start) go <= 1'b1;
         if (fall) begin
            if (go) begin
               go    <= 1'b0;
               state <= TX_BUSY;
               busy  <= 1'b1;
               dout  <= 1'b0;
               shreg <= short_res ? {sample[SAMPLE_W-1 -: SHORT_W], {PAD_W{1'b0}}} : sample;
               left  <= short_res ? LEFT_W'(SHORT_W) : LEFT_W'(SAMPLE_W);
            end else begin
               case (state)
                  TX_BUSY: begin
                     busy  <= 1'b0;
                     dout  <= shreg[SAMPLE_W-1];
                     shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
                     left  <= left - LEFT_W'(1);
                     state <= TX_SHIFT;
                  end
                  TX_SHIFT: begin
                     if (left == '0) begin
                        dout  <= 1'b0;
                        state <= TX_IDLE;
                     end else begin
                        dout  <= shreg[SAMPLE_W-1];
                        shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
                        left  <= left - LEFT_W'(1);
                     end
                  end
                  default: dout <= 1'b0;
               endcase
            end
         end
      end
   end

   assign conv_active = (state != TX_IDLE);

endmodule

// File: rtl/tadc_pwr_ctl.sv
module tadc_pwr_ctl
   import touch_adc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cmd_valid,
   input  pwr_mode_t pwr_mode,
   input  logic      single_ref,
   input  logic      conv_active,
   output logic      powered,
   output logic      penirq_en,
   output logic      yneg_sw,
   output logic      ratio_sw,
   output logic      rsvd_flag
);
   logic doze_pen;

   // Codes 1x keep the core up; the reserved code behaves like always-on.
   assign powered   = pwr_mode[1] | conv_active;
   assign doze_pen  = (pwr_mode == PWR_DOZE_PEN) & ~conv_active;
   assign penirq_en = doze_pen;
   assign yneg_sw   = doze_pen;
   assign ratio_sw  = conv_active & ~single_ref;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                   rsvd_flag <= 1'b0;
      else if (cmd_valid && pwr_mode == PWR_RSVD)   rsvd_flag <= 1'b1;
   end

endmodule

// File: rtl/touch_adc_serial.sv
module touch_adc_serial
   import touch_adc_pkg::*;
#(
   parameter int SAMPLE_W    = 12,
   parameter int SHORT_W     = 8,
   parameter int FRAME_LONG  = 16,
   parameter int FRAME_SHORT = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cs_n,
   input  logic                sclk,
   input  logic                din,
   input  logic [SAMPLE_W-1:0] sample_in,
   output logic                dout,
   output logic                dout_oe,
   output logic                busy,
   output logic [2:0]          chan_sel,
   output logic                powered,
   output logic                penirq_en,
   output logic                yneg_sw,
   output logic                ratio_sw,
   output logic                rsvd_flag
);
   generate
      if (SAMPLE_W <= SHORT_W) begin : g_bad_width
         $error("SAMPLE_W must exceed SHORT_W");
      end
      if (FRAME_SHORT <= CMD_BITS || FRAME_LONG < FRAME_SHORT) begin : g_bad_frame
         $error("frame lengths must exceed the command length and be ordered");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic cs_act;
   logic din_s;
   logic rise;
   logic fall;
   logic cmd_valid;
   logic conv_active;
   cmd_t cmd;

   tadc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .cs_n_in (cs_n),
      .sclk_in (sclk),
      .din_in  (din),
      .cs_act  (cs_act),
      .din_s   (din_s),
      .rise    (rise),
      .fall    (fall)
   );

   tadc_cmd_rx #(.FRAME_LONG(FRAME_LONG), .FRAME_SHORT(FRAME_SHORT)) u_rx (
      .clk       (clk),
      .rst_n     (rst_n),
      .cs_act    (cs_act),
      .rise      (rise),
      .din       (din_s),
      .cmd_valid (cmd_valid),
      .cmd       (cmd)
   );

   tadc_res_tx #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .cs_act      (cs_act),
      .fall        (fall),
      .start       (cmd_valid),
      .short_res   (cmd.short_res),
      .sample      (sample_in),
      .busy        (busy),
      .dout        (dout),
      .conv_active (conv_active)
   );

   tadc_pwr_ctl u_pwr (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_valid   (cmd_valid),
      .pwr_mode    (cmd.pwr),
      .single_ref  (cmd.single_ref),
      .conv_active (conv_active),
      .powered     (powered),
      .penirq_en   (penirq_en),
      .yneg_sw     (yneg_sw),
      .ratio_sw    (ratio_sw),
      .rsvd_flag   (rsvd_flag)
   );

   assign dout_oe  = cs_act;
   assign chan_sel = cmd.chan;

endmodule

// File: rtl/touch_adc_serial_chk.sv
module touch_adc_serial_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cs_act,
   input logic       cmd_valid,
   input logic       conv_active,
   input logic       busy,
   input logic       dout,
   input logic       ratio_sw,
   input logic       rsvd_flag,
   input logic [2:0] chan_sel
);
   assert_abort_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_act |=> (!busy && !dout && !conv_active));

   assert_busy_in_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (conv_active && !dout));

   assert_busy_starts_conv_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(conv_active) |-> busy);

   assert_ratio_in_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ratio_sw |-> conv_active);

   assert_rsvd_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rsvd_flag |=> rsvd_flag);

   assert_chan_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |-> $stable(chan_sel));

   assert_cmd_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> !cmd_valid);

endmodule

bind touch_adc_serial touch_adc_serial_chk u_chk (.*);

// File: tb/touch_adc_serial_bench.sv
module touch_adc_serial_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        din = 1'b0;
   logic [11:0] sample_in;
   logic        dout, dout_oe, busy, powered, penirq_en, yneg_sw, ratio_sw, rsvd_flag;
   logic [2:0]  chan_sel;

   int n_chk = 0;
   int n_bad = 0;

   logic obs_dout  [64];
   logic obs_busy  [64];
   logic obs_ratio [64];
   logic obs_pow   [64];

   always #4 clk = ~clk;

   touch_adc_serial u_touch_adc_serial (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .din(din),
      .sample_in(sample_in), .dout(dout), .dout_oe(dout_oe), .busy(busy),
      .chan_sel(chan_sel), .powered(powered), .penirq_en(penirq_en),
      .yneg_sw(yneg_sw), .ratio_sw(ratio_sw), .rsvd_flag(rsvd_flag)
   );

   // Stand-in for the analog core: each channel reads a distinct value
   function automatic logic [11:0] smp(input logic [2:0] ch);
      return 12'(ch * 12'h2B7 + 12'h0C1);
   endfunction

   function automatic logic [11:0] smp_hi(input logic [2:0] ch);
      logic [11:0] v = smp(ch);
      return {4'h0, v[11:4]};
   endfunction

   assign sample_in = smp(chan_sel);

   function automatic logic [7:0] mk(input logic [2:0] ch, input logic m,
                                     input logic s, input logic [1:0] pd);
      return {1'b1, ch, m, s, pd};
   endfunction

   function automatic logic [31:0] word_at(input int first, input int nb);
      logic [31:0] w = '0;
      for (int k = 0; k < nb; k++) w = {w[30:0], obs_dout[first + k]};
      return w;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One serial clock per bit; outputs sampled late in the high phase
   task automatic run_seq(input int n, input logic [63:0] bits);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); din = bits[n-1-i];
         repeat (3) @(negedge clk); sclk = 1'b1;
         repeat (4) @(negedge clk);
         obs_dout[i]  = dout;
         obs_busy[i]  = busy;
         obs_ratio[i] = ratio_sw;
         obs_pow[i]   = powered;
         sclk = 1'b0;
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic reselect();
      @(negedge clk); cs_n = 1'b1;
      repeat (6) @(negedge clk); cs_n = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R12 busy", busy, 0);
      chk("R12 dout", dout, 0);
      chk("R12 dout_oe", dout_oe, 0);
      chk("R12 powered", powered, 0);
      chk("R12 rsvd_flag", rsvd_flag, 0);
      chk("R12 penirq_en", penirq_en, 1);
      chk("R12 yneg_sw", yneg_sw, 1);
   endtask

   task automatic t_basic12();
      int off = 3;
      reselect();
      chk("R4 dout_oe while selected", dout_oe, 1);
      run_seq(27, {37'b0, 3'b000, mk(3'd5, 1'b0, 1'b1, 2'b00), 16'h0});
      chk("R2 channel decode", chan_sel, 5);
      chk("R1 busy aligned after leading zeros", obs_busy[off+8], 1);
      chk("R3 busy low before", obs_busy[off+7], 0);
      chk("R3 busy low after", obs_busy[off+9], 0);
      chk("R4 12-bit result", word_at(off+9, 12), smp(3'd5));
      chk("R4 trailing zeros", word_at(off+21, 3), 0);
      chk("R6 single-ended ratio_sw low", obs_ratio[off+9], 0);
      chk("R8 powered during conversion", obs_pow[off+9], 1);
      chk("R8 powered idle", powered, 0);
      chk("R8 penirq_en idle", penirq_en, 1);
      chk("R8 yneg_sw idle", yneg_sw, 1);
   endtask

   task automatic t_short_diff();
      reselect();
      run_seq(24, {40'b0, mk(3'd2, 1'b1, 1'b0, 2'b01), 16'h0});
      chk("R5 8-bit result", word_at(9, 8), smp_hi(3'd2));
      chk("R5 zero after 8 bits", obs_dout[17], 0);
      chk("R6 ratio_sw during conversion", obs_ratio[9], 1);
      chk("R6 ratio_sw after conversion", obs_ratio[17], 0);
      chk("R9 powered during conversion", obs_pow[12], 1);
      chk("R9 powered idle", powered, 0);
      chk("R9 penirq_en", penirq_en, 0);
      chk("R9 yneg_sw", yneg_sw, 0);
   endtask

   task automatic t_overlap12();
      reselect();
      run_seq(40, {24'b0, mk(3'd1, 1'b0, 1'b1, 2'b11), 8'hFF,
                   mk(3'd6, 1'b0, 1'b1, 2'b11), 16'h0});
      chk("R7 first 12-bit result", word_at(9, 12), smp(3'd1));
      chk("R7 second busy at clock 25", obs_busy[24], 1);
      chk("R7 second 12-bit result", word_at(25, 12), smp(3'd6));
      chk("R7 second channel", chan_sel, 6);
      chk("R10 mode 11 powered idle", powered, 1);
      chk("R10 mode 11 penirq_en", penirq_en, 0);
   endtask

   task automatic t_overlap8();
      reselect();
      run_seq(32, {32'b0, mk(3'd7, 1'b1, 1'b1, 2'b11), 4'hF,
                   mk(3'd4, 1'b1, 1'b1, 2'b11), 12'h0});
      chk("R7 first 8-bit result", word_at(9, 8), smp_hi(3'd7));
      chk("R7 second busy at clock 21", obs_busy[20], 1);
      chk("R7 second 8-bit result", word_at(21, 8), smp_hi(3'd4));
   endtask

   task automatic t_reserved();
      reselect();
      run_seq(20, {44'b0, mk(3'd0, 1'b1, 1'b1, 2'b10), 12'h0});
      chk("R10 reserved sets flag", rsvd_flag, 1);
      chk("R10 reserved powered idle", powered, 1);
      chk("R10 reserved yneg_sw", yneg_sw, 0);
      run_seq(20, {44'b0, mk(3'd0, 1'b1, 1'b1, 2'b00), 12'h0});
      chk("R10 flag sticky", rsvd_flag, 1);
      chk("R8 back to power-down", powered, 0);
   endtask

   task automatic t_abort();
      reselect();
      run_seq(10, {54'b0, mk(3'd3, 1'b0, 1'b0, 2'b00), 2'b00});
      chk("R11 busy seen before abort", obs_busy[8], 1);
      @(negedge clk); cs_n = 1'b1;
      repeat (8) @(negedge clk);
      chk("R11 dout_oe after abort", dout_oe, 0);
      chk("R11 busy after abort", busy, 0);
      chk("R11 ratio_sw after abort", ratio_sw, 0);
      cs_n = 1'b0;
      repeat (6) @(negedge clk);
      run_seq(4, {60'b0, 4'b1011});
      reselect();
      run_seq(24, {40'b0, mk(3'd6, 1'b0, 1'b1, 2'b00), 16'h0});
      chk("R11 fresh frame channel", chan_sel, 6);
      chk("R11 fresh frame result", word_at(9, 12), smp(3'd6));
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_basic12();
      t_short_diff();
      t_overlap12();
      t_overlap8();
      t_reserved();
      t_abort();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

endmodule